// File: doc/BRIEF.md
# SPI Command Front End for a Serial Port

This block is the host-facing control port of a UART peripheral. The host talks to it over a four-wire SPI link, SPI mode 0, using 16-bit full-duplex frames. During each frame the host shifts a command word in on MOSI, most significant bit first. In the same frame the block shifts a response word out on MISO. Every response starts with two status bits: whether receive data is waiting, and whether the transmitter can take another character. The rest of the response is either the configuration word or the head of the receive queue. Which one depends on the command class in the frame.

The block holds the 14-bit configuration word, the RTS level and the low-power shutdown state. It owns a receive queue that the serial line engine fills through a push port. It hands transmit characters to the line engine through a one-cycle push strobe. It also drives an active-low interrupt line from three maskable conditions. The SPI pins are brought into the system clock domain through two-stage synchronisers, and all decoding runs on the system clock. That clock must be at least six times faster than SCLK.

Top module: `spi_uart_cmd`

## Requirements
- R1: A frame is the set of SCLK rising edges while CS_N is low. MOSI is sampled on SCLK rising edges, MSB first. Command bit 15 selects write (1) or read (0), and bit 14 selects configuration (1) or data (0). Response bit 15 is set when the receive queue holds a character at the start of the frame. Response bit 14 mirrors `tx_ready` at the start of the frame.
- R2: A configuration write (bits 15:14 = 11) stores command bits 13:0 as the configuration and drives it on `cfg_word`. In any configuration frame, response bits 13:0 carry the configuration in force while the frame is shifted.
- R3: In a data frame (bit 14 = 0), the response carries the following fields, all sampled at frame start: the head character in bits 7:0, its ninth bit in bit 8, the CTS input in bit 9, and the head's framing-error flag in bit 10. Bits 13:11 are zero, and all character fields are zero when the queue is empty.
- R4: A completed data read (bits 15:14 = 00) removes exactly one character from the queue when response bit 15 was set. It removes nothing otherwise.
- R5: A completed data write (bits 15:14 = 10) always loads RTS from bit 9. When bit 10 is 0 and `tx_ready` is high, it also pulses `tx_push` for one cycle, with `tx_data` equal to command bits 8:0. When bit 10 is 1 or `tx_ready` is low, it queues no character.
- R6: Every completed configuration write empties the receive queue.
- R7: `shutdown` follows configuration bit 12.
- R8: The receive queue keeps `RX_DEPTH` (default 16) characters in arrival order. A push into a full queue is dropped.
- R9: While configuration bit 13 is set, the queue holds at most one character, and further pushes are dropped.
- R10: If CS_N rises before the 16th SCLK rising edge, the frame is aborted. It leaves the configuration, RTS and queue unchanged and queues no character.
- R11: `irq_n` is low, one clock after its inputs change, exactly when any of these holds: data is waiting and configuration bit 10 is set; `tx_ready` is high and bit 11 is set; the head character's ninth bit is 1 and bit 9 is set.
- R12: After reset, the configuration is zero, and RTS, `shutdown`, `tx_push` and MISO are low. `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Command bit from host |
| miso | output | 1 | Response bit to host, low when not selected |
| cts_in | input | 1 | Clear-to-send level from the line |
| rts | output | 1 | Request-to-send level to the line |
| shutdown | output | 1 | Low-power request to the line engine |
| irq_n | output | 1 | Active-low interrupt |
| cfg_word | output | 14 | Current configuration for the line engine |
| rx_push | input | 1 | Line engine delivers a received character |
| rx_data | input | 9 | Received character with ninth bit in bit 8 |
| rx_ferr | input | 1 | Framing error for the delivered character |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_push | output | 1 | One-cycle strobe handing a character to the transmitter |
| tx_data | output | 9 | Character for the transmitter, ninth bit in bit 8 |

## Verification
The bench targets frames that end early and checks that neither the configuration nor the queue moves. A design that acts on a bit count without tracking chip select would apply a half-shifted word or pop a character nobody read. The bench fills the queue past its depth and drains it. A pointer or count slip there shows up as a lost, repeated or reordered character, or as a phantom seventeenth entry. It also checks that a configuration write empties the queue, that a rejected data write still moves RTS, and that the single-entry mode limits the queue to one character. In each of those cases an error appears as stale data in a later response or as an extra `tx_push`.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;
  localparam int FRAME_W = 16;
  localparam int CFG_W   = 14;
  localparam int CHAR_W  = 9;

  // command / response bit positions decoded by neighbours
  localparam int B_WRITE = 15;
  localparam int B_CFG   = 14;
  localparam int B_NOTX  = 10;
  localparam int B_RTS   = 9;

  // configuration field positions
  localparam int C_ONEDEEP = 13;
  localparam int C_SHDN    = 12;
  localparam int C_MTX     = 11;
  localparam int C_MRX     = 10;
  localparam int C_MPAR    = 9;

  typedef struct packed {
    logic              ferr;
    logic [CHAR_W-1:0] word;
  } rx_entry_t;
endpackage

// File: rtl/suc_frame.sv
module suc_frame
  import spi_uart_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] resp,
  output logic               miso,
  output logic               start,
  output logic               done,
  output logic               sel_cfg,
  output logic [FRAME_W-1:0] cmd
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int IDX_W = $clog2(FRAME_W);

  logic sclk_m, sclk_s, sclk_d, cs_m, cs_s, cs_d, mosi_m, mosi_s;
  logic rise, fall, stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 1'b0; sclk_s <= 1'b0; sclk_d <= 1'b0;
      cs_m   <= 1'b1; cs_s   <= 1'b1; cs_d   <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sclk_m <= sclk;   sclk_s <= sclk_m; sclk_d <= sclk_s;
      cs_m   <= cs_n;   cs_s   <= cs_m;   cs_d   <= cs_s;
      mosi_m <= mosi;   mosi_s <= mosi_m;
    end
  end

  assign rise  = sclk_s & ~sclk_d;
  assign fall  = ~sclk_s & sclk_d;
  assign start = cs_d & ~cs_s;
  assign stop  = ~cs_d & cs_s;

  logic               active, active_n;
  logic [CNT_W-1:0]   bitcnt, bitcnt_n;
  logic [FRAME_W-2:0] sr, sr_n;
  logic [IDX_W-1:0]   out_idx, out_idx_n;
  logic               sel_n, done_n;
  logic [FRAME_W-1:0] cmd_n;

  always_comb begin
    active_n  = active;
    bitcnt_n  = bitcnt;
    sr_n      = sr;
    out_idx_n = out_idx;
    sel_n     = sel_cfg;
    done_n    = 1'b0;
    cmd_n     = cmd;
    if (start) begin
      active_n  = 1'b1;
      bitcnt_n  = '0;
      out_idx_n = IDX_W'(FRAME_W - 1);
      sel_n     = 1'b0;
    end else if (stop) begin
      active_n = 1'b0;
    end else if (active) begin
      if (rise && (bitcnt < CNT_W'(FRAME_W))) begin
        sr_n     = {sr[FRAME_W-3:0], mosi_s};
        bitcnt_n = bitcnt + CNT_W'(1);
        if (bitcnt == CNT_W'(1)) sel_n = mosi_s;
        if (bitcnt == CNT_W'(FRAME_W - 1)) begin
          done_n = 1'b1;
          cmd_n  = {sr, mosi_s};
        end
      end
      if (fall && (bitcnt != '0) && (out_idx != '0))
        out_idx_n = out_idx - IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bitcnt  <= '0;
      sr      <= '0;
      out_idx <= '0;
      sel_cfg <= 1'b0;
      done    <= 1'b0;
      cmd     <= '0;
    end else begin
      active  <= active_n;
      bitcnt  <= bitcnt_n;
      sr      <= sr_n;
      out_idx <= out_idx_n;
      sel_cfg <= sel_n;
      done    <= done_n;
      cmd     <= cmd_n;
    end
  end

  assign miso = active ? resp[out_idx] : 1'b0;

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));
endmodule

// File: rtl/suc_rx_fifo.sv
module suc_rx_fifo
  import spi_uart_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t push_ent,
  input  logic      pop,
  input  logic      flush,
  input  logic      one_deep,
  output logic      avail,
  output rx_entry_t head_ent
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n, wr_inc, rd_inc;
  logic [CNT_W-1:0] count, count_n, limit;
  logic             wr_en, rd_en;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr + PTR_W'(1);
      assign rd_inc = rd_ptr + PTR_W'(1);
    end else begin : g_wrap
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  always_comb begin
    limit    = one_deep ? CNT_W'(1) : CNT_W'(DEPTH);
    wr_en    = push && !flush && (count < limit);
    rd_en    = pop && !flush && (count != '0);
    wr_ptr_n = wr_en ? wr_inc : wr_ptr;
    rd_ptr_n = rd_en ? rd_inc : rd_ptr;
    count_n  = count + CNT_W'(wr_en) - CNT_W'(rd_en);
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_ent;
  end

  assign avail    = (count != '0);
  assign head_ent = mem[rd_ptr];

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R9
  one_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_deep && count <= CNT_W'(1)) |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/suc_irq.sv
module suc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_avail,
  input  logic tx_ready,
  input  logic head_par,
  input  logic mask_rx,
  input  logic mask_tx,
  input  logic mask_par,
  output logic irq_n
);
  logic irq_n_n;

  always_comb begin
    irq_n_n = ~((rx_avail & mask_rx) |
                (tx_ready & mask_tx) |
                (rx_avail & head_par & mask_par));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= irq_n_n;
  end

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(mask_rx | mask_tx | mask_par));
endmodule

// File: rtl/spi_uart_cmd.sv
module spi_uart_cmd
  import spi_uart_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              cts_in,
  output logic              rts,
  output logic              shutdown,
  output logic              irq_n,
  output logic [CFG_W-1:0]  cfg_word,
  input  logic              rx_push,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              tx_ready,
  output logic              tx_push,
  output logic [CHAR_W-1:0] tx_data
);
  logic               start, done, sel_cfg;
  logic [FRAME_W-1:0] cmd, resp;
  logic               rx_avail, rx_pop, rx_flush;
  rx_entry_t          head, push_ent;

  logic [CFG_W-1:0]  cfg, cfg_n;
  logic              rts_n, txp_n;
  logic [CHAR_W-1:0] txd_n;
  logic              snap_av, snap_txr, snap_cts;
  rx_entry_t         snap_head;

  suc_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .resp(resp), .miso(miso), .start(start), .done(done),
    .sel_cfg(sel_cfg), .cmd(cmd)
  );

  assign push_ent.ferr = rx_ferr;
  assign push_ent.word = rx_data;

  suc_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_ent(push_ent),
    .pop(rx_pop), .flush(rx_flush), .one_deep(cfg[C_ONEDEEP]),
    .avail(rx_avail), .head_ent(head)
  );

  suc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rx_avail(rx_avail), .tx_ready(tx_ready),
    .head_par(head.word[CHAR_W-1]), .mask_rx(cfg[C_MRX]),
    .mask_tx(cfg[C_MTX]), .mask_par(cfg[C_MPAR]), .irq_n(irq_n)
  );

  // response word: status on top, config or data fields below
  always_comb begin
    resp = '0;
    resp[B_WRITE] = snap_av;
    resp[B_CFG]   = snap_txr;
    if (sel_cfg) begin
      resp[CFG_W-1:0] = cfg;
    end else begin
      resp[B_NOTX]       = snap_head.ferr;
      resp[B_RTS]        = snap_cts;
      resp[CHAR_W-1:0]   = snap_head.word;
    end
  end

  // command execution at frame completion
  always_comb begin
    cfg_n    = cfg;
    rts_n    = rts;
    txp_n    = 1'b0;
    txd_n    = tx_data;
    rx_pop   = 1'b0;
    rx_flush = 1'b0;
    if (done) begin
      case (cmd[B_WRITE:B_CFG])
        2'b11: begin
          cfg_n    = cmd[CFG_W-1:0];
          rx_flush = 1'b1;
        end
        2'b10: begin
          rts_n = cmd[B_RTS];
          if (!cmd[B_NOTX] && tx_ready) begin
            txp_n = 1'b1;
            txd_n = cmd[CHAR_W-1:0];
          end
        end
        2'b00:   rx_pop = snap_av;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      rts       <= 1'b0;
      tx_push   <= 1'b0;
      tx_data   <= '0;
      snap_av   <= 1'b0;
      snap_txr  <= 1'b0;
      snap_cts  <= 1'b0;
      snap_head <= '0;
    end else begin
      cfg     <= cfg_n;
      rts     <= rts_n;
      tx_push <= txp_n;
      tx_data <= txd_n;
      if (start) begin
        snap_av   <= rx_avail;
        snap_txr  <= tx_ready;
        snap_cts  <= cts_in;
        snap_head <= rx_avail ? head : '0;
      end
    end
  end

  assign cfg_word = cfg;
  assign shutdown = cfg[C_SHDN];

  // R4
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_avail);

  // R5
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);

  // R2
  cfg_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(cfg_word));
endmodule

// File: tb/sim_spi_uart_cmd.sv
module sim_spi_uart_cmd;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, cts_in = 1'b1;
  logic rx_push = 1'b0, rx_ferr = 1'b0, tx_ready = 1'b1;
  logic [8:0] rx_data = '0;
  logic miso, rts, shutdown, irq_n, tx_push;
  logic [13:0] cfg_word;
  logic [8:0] tx_data;

  int n_cmp = 0, n_bad = 0, n_txp = 0;
  logic [8:0] last_tx = '0;
  localparam int HALF = 6;

  always #4 clk = ~clk;

  spi_uart_cmd u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .cts_in(cts_in), .rts(rts), .shutdown(shutdown),
    .irq_n(irq_n), .cfg_word(cfg_word), .rx_push(rx_push),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .tx_ready(tx_ready),
    .tx_push(tx_push), .tx_data(tx_data)
  );

  always @(negedge clk) if (tx_push) begin n_txp++; last_tx = tx_data; end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] c, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = c[15-i];
      repeat (HALF) @(negedge clk);
      r[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic push(input logic [8:0] d, input logic fe);
    @(negedge clk); rx_push = 1'b1; rx_data = d; rx_ferr = fe;
    @(negedge clk); rx_push = 1'b0; rx_ferr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] VEC [6] = '{
    {16'h4000, 16'h4000},  // R2 config read after reset
    {16'hC025, 16'h4000},  // R2 config write returns prior config
    {16'h4000, 16'h4025},  // R2 new config read back
    {16'h0000, 16'h4200},  // R1 R3 empty data read, CTS in bit 9
    {16'h8600, 16'h4200},  // R5 RTS-only write
    {16'h815A, 16'h4200}   // R5 character write
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 outputs", {8'h0, rts, shutdown, irq_n, tx_push, miso, 3'b0},
        {8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0});
    chk("R12 cfg", {2'b0, cfg_word}, 16'h0);

    foreach (VEC[k]) begin
      xfer(VEC[k][31:16], 16, r);
      chk("R1 R2 R3 R5 vector", r, VEC[k][15:0]);
    end
    chk("R5 rts from last write", {15'h0, rts}, 16'h0);
    chk("R5 one tx push", n_txp[15:0], 16'd1);
    chk("R5 tx word", {7'h0, last_tx}, 16'h015A);
    xfer(16'h8600, 16, r);
    chk("R5 rts set by no-tx write", {15'h0, rts}, 16'h1);
    chk("R5 no push when bit10 set", n_txp[15:0], 16'd1);
    tx_ready = 1'b0;
    xfer(16'h8012, 16, r);
    chk("R5 no push when tx busy", n_txp[15:0], 16'd1);
    tx_ready = 1'b1;

    push(9'h141, 1'b0); push(9'h0AB, 1'b0);
    xfer(16'h0000, 16, r); chk("R3 R4 first char", r, 16'hC341);
    xfer(16'h0000, 16, r); chk("R4 second char", r, 16'hC2AB);
    xfer(16'h0000, 16, r); chk("R4 empty after pops", r, 16'h4200);
    push(9'h055, 1'b1);
    xfer(16'h0000, 16, r); chk("R3 framing error bit", r, 16'hC655);

    push(9'h011, 1'b0);
    xfer(16'h4000, 16, r); chk("R1 R2 status in config read", r, 16'hC025);
    xfer(16'hC000, 16, r);
    xfer(16'h0000, 16, r); chk("R6 flush on config write", r, 16'h4200);
    chk("R2 cfg port", {2'b0, cfg_word}, 16'h0);

    cts_in = 1'b0;
    xfer(16'h0000, 16, r); chk("R3 cts low", r, 16'h4000);
    cts_in = 1'b1;

    for (int i = 0; i < 17; i++) push(9'(i + 1), 1'b0);
    for (int i = 0; i < 16; i++) begin
      xfer(16'h0000, 16, r);
      chk("R8 order", r, 16'hC200 | 16'(i + 1));
    end
    xfer(16'h0000, 16, r); chk("R8 overflow dropped", r, 16'h4200);

    push(9'h077, 1'b0);
    xfer(16'h0000, 8, r);
    xfer(16'hD000, 8, r);
    chk("R10 cfg untouched", {1'b0, shutdown, cfg_word}, 16'h0);
    xfer(16'h0000, 16, r); chk("R10 char kept", r, 16'hC277);

    xfer(16'hD000, 16, r);
    chk("R7 shutdown on", {1'b0, shutdown, cfg_word}, 16'h5000);
    xfer(16'hC000, 16, r);
    chk("R7 shutdown off", {15'h0, shutdown}, 16'h0);

    xfer(16'hE000, 16, r);
    push(9'h0A1, 1'b0); push(9'h0A2, 1'b0);
    xfer(16'h0000, 16, r); chk("R9 single entry", r, 16'hC2A1);
    xfer(16'h0000, 16, r); chk("R9 second dropped", r, 16'h4200);

    xfer(16'hC400, 16, r);
    chk("R11 idle high", {15'h0, irq_n}, 16'h1);
    push(9'h033, 1'b0);
    chk("R11 rx data low", {15'h0, irq_n}, 16'h0);
    xfer(16'h0000, 16, r);
    chk("R11 released after pop", {15'h0, irq_n}, 16'h1);
    xfer(16'hC800, 16, r);
    chk("R11 tx empty low", {15'h0, irq_n}, 16'h0);
    tx_ready = 1'b0; repeat (3) @(negedge clk);
    chk("R11 tx busy high", {15'h0, irq_n}, 16'h1);
    tx_ready = 1'b1;
    xfer(16'hC200, 16, r);
    push(9'h044, 1'b0);
    chk("R11 parity 0 high", {15'h0, irq_n}, 16'h1);
    xfer(16'h0000, 16, r);
    push(9'h100, 1'b0);
    chk("R11 parity 1 low", {15'h0, irq_n}, 16'h0);
    xfer(16'h0000, 16, r);
    chk("R11 parity pop high", {15'h0, irq_n}, 16'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule